// File: doc/BRIEF.md
# Stack Bytecode Instruction Folder

This block sits after the bytecode decoder of a stack-machine core. It receives one decoded instruction per handshake. Each instruction is an 8-bit opcode, a 3-bit folding class and one literal. The literal is the load value for a load and the target slot for a store. Short runs of instructions match a fixed table of patterns: loads feeding an operation, optionally followed by a store. A matching run is merged into one wide execution word. The word names up to two literals, one operation and one destination, plus a count of how many input instructions it stands for.

A small state machine keeps the partly built group in a format register with a valid flag per field. When a new instruction cannot extend the group, the block sends out what it holds before it accepts that instruction. A held run that is a complete pattern goes out as one merged word. An incomplete run is split into one word per instruction. The rejected instruction is then matched again as the first member of a fresh group. Non-foldable and trapped instructions never join a group. A stalled output freezes the whole block.

Top module: `bc_fold`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1 while the output is not stalled.
- R2: Class codes on in_cls are: 0 load, 1 unary op, 2 binary op, 3 unary op that ends a group, 4 binary op that ends a group, 5 store, 6 non-foldable, 7 trapped. The run load,load,binary,store leaves as one word. In that word lit0 holds the first load's literal, lit1 the second load's literal, op the binary opcode and dst the store's literal, each with its valid flag set, and out_n is 4.
- R3: The three-member groups load,load,binary (closed by a following instruction that is not a store), load,load,binary-end, load,unary,store and load,binary,store each leave as one merged word with out_n equal to 3.
- R4: The two-member groups load,unary and load,binary (closed by a following non-store), load,unary-end and load,binary-end leave as one merged word. The word has lit0 and op valid and out_n equal to 2.
- R5: The group load,store leaves as one word with lit0 and dst valid, op_v equal to 0 and out_n equal to 2. The groups unary,store and binary,store leave with op and dst valid and out_n equal to 2.
- R6: A group that ends in a store or in an ending op is emitted with no further input. A complete group that a store could still extend stays held until the next instruction arrives.
- R7: If the held run is not a complete pattern when it is rejected, each held instruction leaves as its own word, in order, with out_n equal to 1. Folding then restarts at the rejected instruction. A lone word carries op_v with the opcode. A lone load also carries lit0, and a lone store carries dst.
- R8: Non-foldable and trapped instructions first flush any held group and then leave alone with out_n equal to 1. out_trap is 1 only for a trapped instruction.
- R9: While out_valid is 1 and out_ready is 0, in_ready is 0 and every output field keeps its value.
- R10: Fields that are not valid in an output word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input instruction present |
| in_ready | output | 1 | Input instruction accepted this cycle |
| in_opc | input | 8 | Instruction opcode |
| in_cls | input | 3 | Folding class code |
| in_lit | input | 16 | Literal: load value or store slot |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_lit0_v | output | 1 | First literal valid |
| out_lit0 | output | 16 | First literal |
| out_lit1_v | output | 1 | Second literal valid |
| out_lit1 | output | 16 | Second literal |
| out_op_v | output | 1 | Operation valid |
| out_op | output | 8 | Operation opcode |
| out_dst_v | output | 1 | Destination valid |
| out_dst | output | 16 | Destination slot |
| out_trap | output | 1 | Word is a trapped instruction |
| out_n | output | 3 | Number of input instructions in the word |

## Verification
The bench uses the package widths as they stand: an 8-bit opcode and 16-bit literals. With those widths every literal and opcode in a run can be unique, so a swapped lit0/lit1, a misplaced destination or a dropped lone word shows up as a field mismatch. The bench drives every table pattern. It also drives each way a group can be rejected: a non-store after a complete group, a non-binary after two loads, and a non-foldable after one load. All of this runs once with the output always ready and once with a stall pattern that holds out_ready low every third cycle. The stalled run brings the hold and input-block behaviour into reach while a flush is in progress.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

    localparam int OPC_W = 8;
    localparam int LIT_W = 16;
    localparam int MAX_GRP = 4;
    localparam int CNT_W = $clog2(MAX_GRP + 1);

    typedef enum logic [2:0] {
        CL_LOAD    = 3'd0,
        CL_UN      = 3'd1,
        CL_BIN     = 3'd2,
        CL_UN_END  = 3'd3,
        CL_BIN_END = 3'd4,
        CL_STORE   = 3'd5,
        CL_NOFOLD  = 3'd6,
        CL_TRAP    = 3'd7
    } fclass_e;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        fclass_e          cls;
        logic [LIT_W-1:0] lit;
    } instr_t;

    typedef struct packed {
        logic             lit0_v;
        logic [LIT_W-1:0] lit0;
        logic             lit1_v;
        logic [LIT_W-1:0] lit1;
        logic             op_v;
        logic [OPC_W-1:0] op;
        logic             dst_v;
        logic [LIT_W-1:0] dst;
        logic             trap;
        logic [CNT_W-1:0] n;
    } word_t;

    typedef struct packed {
        logic             lv0_v;
        logic [OPC_W-1:0] lv0_opc;
        logic [LIT_W-1:0] lv0_lit;
        logic             lv1_v;
        logic [OPC_W-1:0] lv1_opc;
        logic [LIT_W-1:0] lv1_lit;
        logic             op_v;
        logic [OPC_W-1:0] op_opc;
    } hold_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L,
        ST_LL,
        ST_LOP,
        ST_LLOP,
        ST_OP,
        ST_DRAIN
    } fstate_e;

    function automatic word_t load_word(logic [OPC_W-1:0] opc, logic [LIT_W-1:0] lit);
        word_t w;
        w = '0;
        w.op_v   = 1'b1;
        w.op     = opc;
        w.lit0_v = 1'b1;
        w.lit0   = lit;
        w.n      = CNT_W'(1);
        return w;
    endfunction

    function automatic word_t single_word(instr_t i);
        word_t w;
        w = '0;
        w.op_v = 1'b1;
        w.op   = i.opc;
        w.n    = CNT_W'(1);
        if (i.cls == CL_LOAD) begin
            w.lit0_v = 1'b1;
            w.lit0   = i.lit;
        end
        if (i.cls == CL_STORE) begin
            w.dst_v = 1'b1;
            w.dst   = i.lit;
        end
        if (i.cls == CL_TRAP) begin
            w.trap = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/bcf_fmt_reg.sv
module bcf_fmt_reg
    import bcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             ld_lv0,
    input  logic             ld_lv1,
    input  logic             ld_op,
    input  logic             clr,
    input  logic [OPC_W-1:0] opc,
    input  logic [LIT_W-1:0] lit,
    output hold_t            hold
);

    hold_t h_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= '0;
        end else if (en) begin
            if (clr) begin
                h_q <= '0;
            end else begin
                if (ld_lv0) begin
                    h_q.lv0_v   <= 1'b1;
                    h_q.lv0_opc <= opc;
                    h_q.lv0_lit <= lit;
                end
                if (ld_lv1) begin
                    h_q.lv1_v   <= 1'b1;
                    h_q.lv1_opc <= opc;
                    h_q.lv1_lit <= lit;
                end
                if (ld_op) begin
                    h_q.op_v   <= 1'b1;
                    h_q.op_opc <= opc;
                end
            end
        end
    end

    assign hold = h_q;

    // R3: a second literal is never held without a first one
    a_r3_lit_order: assert property (@(posedge clk) disable iff (rst)
        h_q.lv1_v |-> h_q.lv0_v);

endmodule

// File: rtl/bcf_ctrl.sv
module bcf_ctrl
    import bcf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  logic   in_valid,
    input  instr_t in_i,
    input  hold_t  hold,
    output logic   in_ready,
    output logic   emit,
    output word_t  w,
    output logic   ld_lv0,
    output logic   ld_lv1,
    output logic   ld_op,
    output logic   clr
);

    fstate_e st, nxt;
    logic    take_ok;
    logic    is_store;

    assign is_store = (in_i.cls == CL_STORE);

    always_comb begin
        take_ok = 1'b0;
        emit    = 1'b0;
        w       = '0;
        nxt     = st;
        ld_lv0  = 1'b0;
        ld_lv1  = 1'b0;
        ld_op   = 1'b0;
        clr     = 1'b0;
        case (st)
            ST_IDLE: begin
                take_ok = 1'b1;
                if (in_valid) begin
                    case (in_i.cls)
                        CL_LOAD: begin
                            ld_lv0 = 1'b1;
                            nxt    = ST_L;
                        end
                        CL_UN, CL_BIN: begin
                            ld_op = 1'b1;
                            nxt   = ST_OP;
                        end
                        default: begin
                            emit = 1'b1;
                            w    = single_word(in_i);
                        end
                    endcase
                end
            end
            ST_L: begin
                take_ok = !(in_i.cls inside {CL_NOFOLD, CL_TRAP});
                if (in_valid) begin
                    case (in_i.cls)
                        CL_LOAD: begin
                            ld_lv1 = 1'b1;
                            nxt    = ST_LL;
                        end
                        CL_UN, CL_BIN: begin
                            ld_op = 1'b1;
                            nxt   = ST_LOP;
                        end
                        CL_UN_END, CL_BIN_END: begin
                            emit     = 1'b1;
                            w.lit0_v = 1'b1;
                            w.lit0   = hold.lv0_lit;
                            w.op_v   = 1'b1;
                            w.op     = in_i.opc;
                            w.n      = CNT_W'(2);
                            clr      = 1'b1;
                            nxt      = ST_IDLE;
                        end
                        CL_STORE: begin
                            emit     = 1'b1;
                            w.lit0_v = 1'b1;
                            w.lit0   = hold.lv0_lit;
                            w.dst_v  = 1'b1;
                            w.dst    = in_i.lit;
                            w.n      = CNT_W'(2);
                            clr      = 1'b1;
                            nxt      = ST_IDLE;
                        end
                        default: begin
                            emit = 1'b1;
                            w    = load_word(hold.lv0_opc, hold.lv0_lit);
                            clr  = 1'b1;
                            nxt  = ST_IDLE;
                        end
                    endcase
                end
            end
            ST_LL: begin
                take_ok = (in_i.cls inside {CL_BIN, CL_BIN_END});
                if (in_valid) begin
                    case (in_i.cls)
                        CL_BIN: begin
                            ld_op = 1'b1;
                            nxt   = ST_LLOP;
                        end
                        CL_BIN_END: begin
                            emit     = 1'b1;
                            w.lit0_v = 1'b1;
                            w.lit0   = hold.lv0_lit;
                            w.lit1_v = 1'b1;
                            w.lit1   = hold.lv1_lit;
                            w.op_v   = 1'b1;
                            w.op     = in_i.opc;
                            w.n      = CNT_W'(3);
                            clr      = 1'b1;
                            nxt      = ST_IDLE;
                        end
                        default: begin
                            emit = 1'b1;
                            w    = load_word(hold.lv0_opc, hold.lv0_lit);
                            nxt  = ST_DRAIN;
                        end
                    endcase
                end
            end
            ST_DRAIN: begin
                emit = 1'b1;
                w    = load_word(hold.lv1_opc, hold.lv1_lit);
                clr  = 1'b1;
                nxt  = ST_IDLE;
            end
            ST_LOP, ST_LLOP: begin
                take_ok = is_store;
                if (in_valid) begin
                    emit     = 1'b1;
                    w.lit0_v = 1'b1;
                    w.lit0   = hold.lv0_lit;
                    w.op_v   = 1'b1;
                    w.op     = hold.op_opc;
                    if (st == ST_LLOP) begin
                        w.lit1_v = 1'b1;
                        w.lit1   = hold.lv1_lit;
                    end
                    w.n = (st == ST_LLOP) ? CNT_W'(3) : CNT_W'(2);
                    if (is_store) begin
                        w.dst_v = 1'b1;
                        w.dst   = in_i.lit;
                        w.n     = w.n + CNT_W'(1);
                    end
                    clr = 1'b1;
                    nxt = ST_IDLE;
                end
            end
            ST_OP: begin
                take_ok = is_store;
                if (in_valid) begin
                    emit   = 1'b1;
                    w.op_v = 1'b1;
                    w.op   = hold.op_opc;
                    w.n    = CNT_W'(1);
                    if (is_store) begin
                        w.dst_v = 1'b1;
                        w.dst   = in_i.lit;
                        w.n     = CNT_W'(2);
                    end
                    clr = 1'b1;
                    nxt = ST_IDLE;
                end
            end
            default: begin
                clr = 1'b1;
                nxt = ST_IDLE;
            end
        endcase
    end

    assign in_ready = adv && take_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else if (adv) begin
            st <= nxt;
        end
    end

    // R7: a pending drain never takes a new instruction
    a_r7_drain_blocks: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DRAIN) |-> !in_ready);

    // R6: a held group only extends while the format register shows a load
    a_r6_group_has_load: assert property (@(posedge clk) disable iff (rst)
        (st inside {ST_L, ST_LL, ST_LOP, ST_LLOP}) |-> hold.lv0_v);

endmodule

// File: rtl/bcf_out_stage.sv
module bcf_out_stage
    import bcf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  emit,
    input  word_t w_in,
    input  logic  out_ready,
    output logic  adv,
    output logic  out_valid,
    output word_t w_q
);

    logic  v_q;
    word_t d_q;

    assign adv = !v_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
            d_q <= '0;
        end else if (adv) begin
            v_q <= emit;
            if (emit) begin
                d_q <= w_in;
            end
        end
    end

    assign out_valid = v_q;
    assign w_q       = d_q;

    // R9: a stalled word stays put
    a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
        (v_q && !out_ready) |=> (v_q && $stable(d_q)));

    // R2: group size stays within one to four
    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        v_q |-> (d_q.n >= CNT_W'(1) && d_q.n <= CNT_W'(MAX_GRP)));

    // R5: a word without an operation is a load-to-store move
    a_r5_move_shape: assert property (@(posedge clk) disable iff (rst)
        (v_q && !d_q.op_v) |-> (d_q.n == CNT_W'(2) && d_q.lit0_v && d_q.dst_v && !d_q.lit1_v));

    // R8: a trap word stands alone
    a_r8_trap_alone: assert property (@(posedge clk) disable iff (rst)
        (v_q && d_q.trap) |-> (d_q.n == CNT_W'(1)));

endmodule

// File: rtl/bc_fold.sv
module bc_fold
    import bcf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OPC_W-1:0] in_opc,
    input  logic [2:0]       in_cls,
    input  logic [LIT_W-1:0] in_lit,
    output logic             out_valid,
    input  logic             out_ready,
    output logic             out_lit0_v,
    output logic [LIT_W-1:0] out_lit0,
    output logic             out_lit1_v,
    output logic [LIT_W-1:0] out_lit1,
    output logic             out_op_v,
    output logic [OPC_W-1:0] out_op,
    output logic             out_dst_v,
    output logic [LIT_W-1:0] out_dst,
    output logic             out_trap,
    output logic [CNT_W-1:0] out_n
);

    instr_t in_i;
    hold_t  hold;
    word_t  w_next;
    word_t  w_q;
    logic   adv, emit, ld_lv0, ld_lv1, ld_op, clr;

    assign in_i.opc = in_opc;
    assign in_i.cls = fclass_e'(in_cls);
    assign in_i.lit = in_lit;

    bcf_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .in_valid (in_valid),
        .in_i     (in_i),
        .hold     (hold),
        .in_ready (in_ready),
        .emit     (emit),
        .w        (w_next),
        .ld_lv0   (ld_lv0),
        .ld_lv1   (ld_lv1),
        .ld_op    (ld_op),
        .clr      (clr)
    );

    bcf_fmt_reg u_fmt (
        .clk    (clk),
        .rst    (rst),
        .en     (adv),
        .ld_lv0 (ld_lv0),
        .ld_lv1 (ld_lv1),
        .ld_op  (ld_op),
        .clr    (clr),
        .opc    (in_opc),
        .lit    (in_lit),
        .hold   (hold)
    );

    bcf_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .emit      (emit),
        .w_in      (w_next),
        .out_ready (out_ready),
        .adv       (adv),
        .out_valid (out_valid),
        .w_q       (w_q)
    );

    assign out_lit0_v = w_q.lit0_v;
    assign out_lit0   = w_q.lit0;
    assign out_lit1_v = w_q.lit1_v;
    assign out_lit1   = w_q.lit1;
    assign out_op_v   = w_q.op_v;
    assign out_op     = w_q.op;
    assign out_dst_v  = w_q.dst_v;
    assign out_dst    = w_q.dst;
    assign out_trap   = w_q.trap;
    assign out_n      = w_q.n;

    // R9: no instruction enters while the output word waits
    a_r9_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/bc_fold_bench.sv
module bc_fold_bench;
    import bcf_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [OPC_W-1:0] in_opc = '0;
    logic [2:0]       in_cls = '0;
    logic [LIT_W-1:0] in_lit = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic             out_lit0_v, out_lit1_v, out_op_v, out_dst_v, out_trap;
    logic [LIT_W-1:0] out_lit0, out_lit1, out_dst;
    logic [OPC_W-1:0] out_op;
    logic [CNT_W-1:0] out_n;

    always #5 clk = ~clk;

    bc_fold u_bc_fold (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_opc(in_opc), .in_cls(in_cls), .in_lit(in_lit),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_lit0_v(out_lit0_v), .out_lit0(out_lit0),
        .out_lit1_v(out_lit1_v), .out_lit1(out_lit1),
        .out_op_v(out_op_v), .out_op(out_op),
        .out_dst_v(out_dst_v), .out_dst(out_dst),
        .out_trap(out_trap), .out_n(out_n)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    stall_en = 1'b0;
    int    cyc = 0;

    typedef struct {
        word_t w;
        string req;
    } exp_t;
    exp_t exp_q[$];

    fclass_e ptab [12][4];
    int      plen [12];
    instr_t  pend [4];
    int      np = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic bit fits(fclass_e s[4], int sl, int mode);
        for (int k = 0; k < 12; k++) begin
            bit m;
            m = (mode == 0) ? (plen[k] >= sl) : (mode == 1) ? (plen[k] == sl) : (plen[k] > sl);
            for (int i = 0; i < sl; i++) if (ptab[k][i] != s[i]) m = 1'b0;
            if (m) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic word_t ref_single(instr_t i);
        word_t w = '0;
        w.op_v = 1; w.op = i.opc; w.n = 1;
        if (i.cls == CL_LOAD)  begin w.lit0_v = 1; w.lit0 = i.lit; end
        if (i.cls == CL_STORE) begin w.dst_v = 1; w.dst = i.lit; end
        if (i.cls == CL_TRAP)  w.trap = 1;
        return w;
    endfunction

    function automatic word_t ref_group();
        word_t w = '0;
        w.n = CNT_W'(np);
        for (int i = 0; i < np; i++) begin
            if (pend[i].cls == CL_LOAD) begin
                if (!w.lit0_v) begin w.lit0_v = 1; w.lit0 = pend[i].lit; end
                else begin w.lit1_v = 1; w.lit1 = pend[i].lit; end
            end else if (pend[i].cls == CL_STORE) begin
                w.dst_v = 1; w.dst = pend[i].lit;
            end else begin
                w.op_v = 1; w.op = pend[i].opc;
            end
        end
        return w;
    endfunction

    task automatic expect_word(word_t w);
        exp_t e;
        e.w = w; e.req = cur_req;
        exp_q.push_back(e);
    endtask

    task automatic model_push(instr_t c);
        fclass_e s[4];
        forever begin
            for (int i = 0; i < 4; i++) s[i] = (i < np) ? pend[i].cls : CL_NOFOLD;
            if (np < 4) s[np] = c.cls;
            if (np < 4 && fits(s, np + 1, 0)) begin
                pend[np] = c;
                np++;
                if (fits(s, np, 1) && !fits(s, np, 2)) begin
                    expect_word(ref_group());
                    np = 0;
                end
                return;
            end
            if (np == 0) begin
                expect_word(ref_single(c));
                return;
            end
            for (int i = 0; i < 4; i++) s[i] = (i < np) ? pend[i].cls : CL_NOFOLD;
            if (fits(s, np, 1)) expect_word(ref_group());
            else for (int i = 0; i < np; i++) expect_word(ref_single(pend[i]));
            np = 0;
        end
    endtask

    task automatic send(fclass_e c, logic [OPC_W-1:0] op, logic [LIT_W-1:0] lit);
        instr_t t;
        t.opc = op; t.cls = c; t.lit = lit;
        @(negedge clk);
        in_valid = 1'b1; in_opc = op; in_cls = c; in_lit = lit;
        model_push(t);
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        #2;
        out_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
    end

    word_t act_w, prev_w;
    bit    prev_stall = 1'b0;
    always @(negedge clk) begin
        act_w = '{out_lit0_v, out_lit0, out_lit1_v, out_lit1, out_op_v, out_op,
                  out_dst_v, out_dst, out_trap, out_n};
        if (!rst) begin
            if (prev_stall) begin
                chk(out_valid && act_w == prev_w, "R9", "stalled word held", act_w, prev_w);
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R9", "in_ready during stall", 64'(in_ready), 64'(0));
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected word", act_w, 64'(0));
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(act_w == e.w, e.req, "word", act_w, e.w);
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_w     = act_w;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 64'(0), 64'(1));
        finish_run();
    end

    task automatic pending_is(int k, string what);
        chk(exp_q.size() == k, cur_req, what, 64'(exp_q.size()), 64'(k));
    endtask

    task automatic run_all();
        // R2: four-member group
        cur_req = "R2";
        send(CL_LOAD, 8'h10, 16'h1111); send(CL_LOAD, 8'h11, 16'h2222);
        send(CL_BIN, 8'h60, 16'h0); send(CL_STORE, 8'h36, 16'h0007);
        idle(4); pending_is(0, "four-group delivered");
        // R3: three-member groups; R6: extendable group held
        cur_req = "R3";
        send(CL_LOAD, 8'h12, 16'h0A01); send(CL_LOAD, 8'h13, 16'h0A02); send(CL_BIN, 8'h64, 16'h0);
        idle(4);
        cur_req = "R6"; pending_is(0, "extendable group held, nothing sent");
        cur_req = "R3";
        send(CL_LOAD, 8'h14, 16'h0B01); send(CL_LOAD, 8'h15, 16'h0B02); send(CL_BIN_END, 8'h9F, 16'h0);
        send(CL_LOAD, 8'h16, 16'h0C01); send(CL_UN, 8'h74, 16'h0); send(CL_STORE, 8'h37, 16'h0C09);
        send(CL_LOAD, 8'h17, 16'h0D01); send(CL_BIN, 8'h68, 16'h0); send(CL_STORE, 8'h38, 16'h0D09);
        idle(4);
        cur_req = "R6"; pending_is(0, "store-ended group sent without more input");
        // R4: two-member groups
        cur_req = "R4";
        send(CL_LOAD, 8'h18, 16'h0E01); send(CL_UN, 8'h75, 16'h0);
        send(CL_LOAD, 8'h19, 16'h0E02); send(CL_BIN, 8'h6C, 16'h0);
        send(CL_LOAD, 8'h1A, 16'h0E03); send(CL_UN_END, 8'h99, 16'h0);
        send(CL_LOAD, 8'h1B, 16'h0E04); send(CL_BIN_END, 8'hA0, 16'h0);
        idle(4);
        cur_req = "R6"; pending_is(0, "end-op group sent without more input");
        // R5: moves and op-store
        cur_req = "R5";
        send(CL_LOAD, 8'h1C, 16'h0F01); send(CL_STORE, 8'h39, 16'h0F02);
        send(CL_UN, 8'h76, 16'h0); send(CL_STORE, 8'h3A, 16'h0F03);
        send(CL_BIN, 8'h7E, 16'h0); send(CL_STORE, 8'h3B, 16'h0F04);
        // R7: incomplete groups split, restart at rejected instruction
        cur_req = "R7";
        send(CL_LOAD, 8'h1D, 16'h5001); send(CL_LOAD, 8'h1E, 16'h5002); send(CL_UN, 8'h77, 16'h0);
        send(CL_STORE, 8'h3C, 16'h5003);
        send(CL_LOAD, 8'h1F, 16'h5101); send(CL_LOAD, 8'h20, 16'h5102); send(CL_LOAD, 8'h21, 16'h5103);
        send(CL_BIN, 8'h61, 16'h0); send(CL_STORE, 8'h3D, 16'h5104);
        send(CL_UN, 8'h78, 16'h0); send(CL_UN_END, 8'h9A, 16'h0);
        send(CL_STORE, 8'h3E, 16'h5201);
        // R8: non-foldable and trapped
        cur_req = "R8";
        send(CL_TRAP, 8'hCA, 16'h0);
        send(CL_LOAD, 8'h22, 16'h6001); send(CL_TRAP, 8'hCB, 16'h0);
        send(CL_BIN, 8'h62, 16'h0); send(CL_NOFOLD, 8'hB6, 16'h0);
        send(CL_LOAD, 8'h23, 16'h6002); send(CL_LOAD, 8'h24, 16'h6003); send(CL_NOFOLD, 8'hB7, 16'h0);
        // R10: zero fields, plus flush of held complete group
        cur_req = "R10";
        send(CL_LOAD, 8'h25, 16'h7001); send(CL_BIN, 8'h63, 16'h0); send(CL_NOFOLD, 8'hB8, 16'h0);
        idle(5);
        pending_is(0, "all words delivered");
    endtask

    initial begin
        for (int k = 0; k < 12; k++) for (int i = 0; i < 4; i++) ptab[k][i] = CL_NOFOLD;
        ptab[0][0:3]  = '{CL_LOAD, CL_LOAD, CL_BIN, CL_STORE}; plen[0] = 4;
        ptab[1][0:2]  = '{CL_LOAD, CL_LOAD, CL_BIN};           plen[1] = 3;
        ptab[2][0:2]  = '{CL_LOAD, CL_LOAD, CL_BIN_END};       plen[2] = 3;
        ptab[3][0:2]  = '{CL_LOAD, CL_BIN, CL_STORE};          plen[3] = 3;
        ptab[4][0:2]  = '{CL_LOAD, CL_UN, CL_STORE};           plen[4] = 3;
        ptab[5][0:1]  = '{CL_LOAD, CL_UN};                     plen[5] = 2;
        ptab[6][0:1]  = '{CL_LOAD, CL_UN_END};                 plen[6] = 2;
        ptab[7][0:1]  = '{CL_LOAD, CL_BIN};                    plen[7] = 2;
        ptab[8][0:1]  = '{CL_LOAD, CL_BIN_END};                plen[8] = 2;
        ptab[9][0:1]  = '{CL_LOAD, CL_STORE};                  plen[9] = 2;
        ptab[10][0:1] = '{CL_UN, CL_STORE};                    plen[10] = 2;
        ptab[11][0:1] = '{CL_BIN, CL_STORE};                   plen[11] = 2;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'(1));

        stall_en = 1'b0;
        run_all();
        cur_req = "R9";
        stall_en = 1'b1;
        run_all();
        stall_en = 1'b0;
        idle(6);
        chk(exp_q.size() == 0, "R9", "queue drained after stalled run", 64'(exp_q.size()), 64'(0));
        finish_run();
    end

endmodule